// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the clocked control core of a half-bridge gate driver. Upstream comparators have already sorted the PWM command into two indications, "above the high threshold" and "below the low threshold". The block turns those indications into high-side and low-side gate enables. A command that sits between the two thresholds is the mid-level (tri-state) window and turns both switches off. The block does this only after a hold-off, so that glitches and slow edges do not trip it. Leaving the window needs a short settling delay before drive resumes.

Every hand-over between the two switches is break-before-make. The block drops the conducting gate first, and it raises the opposite gate only when two things are true: that gate's discharge feedback shows it is off, and a minimum dead time has passed. A mode input selects one of two low-side behaviours:
- Synchronous operation: the low side is fully complementary to the high side.
- Diode emulation: the low side is released when a reverse-current (zero-cross) flag asserts, and it stays released until the next PWM high-to-low cycle.

Enable and supply-good inputs force both gates off. If discharge feedback never arrives, a timeout latches the block off.

All delays are counts of a fast clock, set by parameters. With the defaults and a 200 MHz clock, the dead time is 4 cycles, the hold-off 34 cycles and the recovery 7 cycles.

Top module: `gsq_gate_sequencer`

## Requirements
- R1: While `en` is low, both gate outputs are low from the first clock edge that samples it low, whatever `pwm_hi`, `pwm_lo` or `sync_mode` do.
- R2: While `supply_ok` is low, both gate outputs are low from the first clock edge that samples it low, whatever the PWM inputs do.
- R3: In synchronous mode (`sync_mode`=1), a high command (`pwm_hi`=1, `pwm_lo`=0) leads to `hs_on`=1 with `ls_on`=0. A low command (`pwm_hi`=0, `pwm_lo`=1) leads to `ls_on`=1 with `hs_on`=0.
- R4: A mid-level command is either both indications low or both high. From an active command, both gates go off only after HOLD_CYC consecutive mid-level samples, with the output dropping one edge later. A shorter mid-level excursion leaves the conducting gate on.
- R5: After both gates were turned off by the mid-level window, a valid level must be sampled on RECOVER_CYC consecutive edges before drive resumes, with the gate rising one edge later. A shorter valid pulse has no effect.
- R6: A gate turns on only in a cycle after the opposite gate's discharge input was sampled high. While that input stays low, both gates stay off.
- R7: Between one gate falling and any gate rising, both gates are low for at least DEAD_CYC cycles. The gap is exactly DEAD_CYC when the discharge feedback is already present.
- R8: In diode-emulation mode (`sync_mode`=0), the high side behaves as in R3. The low side turns on as in R3 but is dropped at the edge after `zero_cross` is sampled high while it conducts. It stays off, even with the low command held, until a high command has been seen. After that, the next low command turns it on again.
- R9: In synchronous mode, `zero_cross` has no effect on `ls_on`.
- R10: If a turn-on waits more than DISCH_TIMEOUT cycles for discharge feedback, the block latches both gates off. Later feedback does not release it. The latch clears only when `en` or `supply_ok` goes low.
- R11: `hs_on` and `ls_on` are never high in the same cycle.
- R12: During and right after reset, both gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Driver enable; low forces both gates off |
| supply_ok | input | 1 | Gate supply above its lockout level |
| sync_mode | input | 1 | 1 = synchronous low side, 0 = diode emulation |
| pwm_hi | input | 1 | PWM above the high threshold |
| pwm_lo | input | 1 | PWM below the low threshold |
| hs_discharged | input | 1 | High-side gate has fallen below its off level |
| ls_discharged | input | 1 | Low-side gate has fallen below its off level |
| zero_cross | input | 1 | Inductor current reversal flag |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The bench measures the dead-time gap, both ways, as a count of cycles. A design that counted from the wrong edge would show a gap one cycle short, or it would let the two gates overlap.

It probes the tri-state filter at its boundaries:
- a 20-cycle excursion must be ignored, and the gate must fall exactly one edge after the 34th mid-level sample;
- a short valid pulse after shutdown must not restart drive;
- the double-asserted input case must behave as mid-level.

A filter that reacted at once, or never, fails these.

It holds each discharge input low to show that a turn-on waits for it. It holds one low long enough to trip the timeout, which must then stay latched until `en` drops. Finally, it applies a zero-cross in both modes: in diode emulation the low side must drop and stay off until a high command, and in synchronous mode nothing may change.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

  // filtered PWM command
  typedef enum logic [1:0] {
    LVL_MID = 2'd0,
    LVL_HI  = 2'd1,
    LVL_LO  = 2'd2
  } lvl_t;

  // which gate the sequencer drives
  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_HS   = 2'd1,
    GATE_LS   = 2'd2
  } gate_t;

endpackage

// File: rtl/gsq_level_filter.sv
// Classifies the two threshold indications and applies the tri-state
// hold-off (R4) and the recovery delay (R5).
module gsq_level_filter
  import gsq_pkg::*;
#(
  parameter int HOLD_CYC    = 34,
  parameter int RECOVER_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_hi,
  input  logic pwm_lo,
  output lvl_t cmd
);

  localparam int RUN_MAX = (HOLD_CYC > RECOVER_CYC) ? HOLD_CYC : RECOVER_CYC;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  lvl_t             raw;
  lvl_t             pend_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_d;

  // both indications at once counts as mid-level (R4)
  always_comb begin
    if (pwm_hi && !pwm_lo)      raw = LVL_HI;
    else if (pwm_lo && !pwm_hi) raw = LVL_LO;
    else                        raw = LVL_MID;
  end

  // consecutive-sample run length of the current raw class
  always_comb begin
    if (raw != pend_q)                   run_d = RUN_W'(1);
    else if (run_q == RUN_W'(RUN_MAX))   run_d = run_q;
    else                                 run_d = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= LVL_MID;
      run_q  <= '0;
      cmd    <= LVL_MID;
    end else begin
      pend_q <= raw;
      run_q  <= run_d;
      if (raw == LVL_MID) begin
        if (cmd != LVL_MID && run_d >= RUN_W'(HOLD_CYC)) cmd <= LVL_MID;
      end else if (cmd != LVL_MID) begin
        cmd <= raw;
      end else if (run_d >= RUN_W'(RECOVER_CYC)) begin
        cmd <= raw;
      end
    end
  end

endmodule

// File: rtl/gsq_bridge_fsm.sv
// Break-before-make sequencing, dead time, discharge timeout and
// diode emulation of the low side.
module gsq_bridge_fsm
  import gsq_pkg::*;
#(
  parameter int DEAD_CYC      = 4,
  parameter int DISCH_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run_ok,
  input  logic sync_mode,
  input  lvl_t cmd,
  input  logic hs_discharged,
  input  logic ls_discharged,
  input  logic zero_cross,
  output logic hs_on,
  output logic ls_on
);

  localparam int DCNT_W = $clog2(DEAD_CYC + 1);
  localparam int TCNT_W = $clog2(DISCH_TIMEOUT + 1);

  gate_t             st_q, st_d;
  gate_t             want;
  logic [DCNT_W-1:0] dcnt_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic              fault_q;
  logic              ls_block_q;
  logic              dead_ok;
  logic              opp_dis;
  logic              waiting;

  // requested gate
  always_comb begin
    want = GATE_NONE;
    if (run_ok && !fault_q) begin
      unique case (cmd)
        LVL_HI:  want = GATE_HS;
        LVL_LO:  want = (!sync_mode && ls_block_q) ? GATE_NONE : GATE_LS;
        default: want = GATE_NONE;
      endcase
    end
  end

  assign dead_ok = dcnt_q >= DCNT_W'(DEAD_CYC - 1);
  assign opp_dis = (want == GATE_HS) ? ls_discharged : hs_discharged;
  assign waiting = (st_q == GATE_NONE) && (want != GATE_NONE) && dead_ok && !opp_dis;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GATE_HS: if (want != GATE_HS) st_d = GATE_NONE;
      GATE_LS: if (want != GATE_LS || (!sync_mode && zero_cross)) st_d = GATE_NONE;
      default: if (want != GATE_NONE && dead_ok && opp_dis) st_d = want;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= GATE_NONE;
      hs_on      <= 1'b0;
      ls_on      <= 1'b0;
      dcnt_q     <= '0;
      tcnt_q     <= '0;
      fault_q    <= 1'b0;
      ls_block_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hs_on <= (st_d == GATE_HS);
      ls_on <= (st_d == GATE_LS);

      // dead-time counter runs only while both gates are off
      if (st_q != GATE_NONE)                  dcnt_q <= '0;
      else if (dcnt_q != DCNT_W'(DEAD_CYC))   dcnt_q <= dcnt_q + DCNT_W'(1);

      // discharge timeout, cleared by dropping enable or supply
      if (!run_ok) begin
        fault_q <= 1'b0;
        tcnt_q  <= '0;
      end else if (waiting) begin
        if (tcnt_q == TCNT_W'(DISCH_TIMEOUT - 1)) fault_q <= 1'b1;
        else                                      tcnt_q  <= tcnt_q + TCNT_W'(1);
      end else begin
        tcnt_q <= '0;
      end

      // diode emulation latch: set by reverse current, cleared by a high command
      if (cmd == LVL_HI)
        ls_block_q <= 1'b0;
      else if (!sync_mode && zero_cross && st_q == GATE_LS)
        ls_block_q <= 1'b1;
    end
  end

endmodule

// File: rtl/gsq_gate_sequencer.sv
module gsq_gate_sequencer
  import gsq_pkg::*;
#(
  parameter int DEAD_CYC      = 4,
  parameter int HOLD_CYC      = 34,
  parameter int RECOVER_CYC   = 7,
  parameter int DISCH_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic supply_ok,
  input  logic sync_mode,
  input  logic pwm_hi,
  input  logic pwm_lo,
  input  logic hs_discharged,
  input  logic ls_discharged,
  input  logic zero_cross,
  output logic hs_on,
  output logic ls_on
);

  lvl_t cmd;
  logic run_ok;

  assign run_ok = en && supply_ok;

  gsq_level_filter #(
    .HOLD_CYC    (HOLD_CYC),
    .RECOVER_CYC (RECOVER_CYC)
  ) u_filter (
    .clk    (clk),
    .rst    (rst),
    .pwm_hi (pwm_hi),
    .pwm_lo (pwm_lo),
    .cmd    (cmd)
  );

  gsq_bridge_fsm #(
    .DEAD_CYC      (DEAD_CYC),
    .DISCH_TIMEOUT (DISCH_TIMEOUT)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .run_ok        (run_ok),
    .sync_mode     (sync_mode),
    .cmd           (cmd),
    .hs_discharged (hs_discharged),
    .ls_discharged (ls_discharged),
    .zero_cross    (zero_cross),
    .hs_on         (hs_on),
    .ls_on         (ls_on)
  );

endmodule

// File: rtl/gsq_gate_sequencer_checker.sv
module gsq_gate_sequencer_checker #(
  parameter int DEAD_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic supply_ok,
  input logic sync_mode,
  input logic zero_cross,
  input logic hs_discharged,
  input logic ls_discharged,
  input logic hs_on,
  input logic ls_on
);

  localparam int LOW_W = $clog2(DEAD_CYC + 1);

  logic [LOW_W-1:0] lowrun_q;

  // consecutive sampled cycles with both gates off
  always_ff @(posedge clk) begin
    if (rst)                        lowrun_q <= '0;
    else if (hs_on || ls_on)        lowrun_q <= '0;
    else if (lowrun_q != LOW_W'(DEAD_CYC)) lowrun_q <= lowrun_q + LOW_W'(1);
  end

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on));

  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    (!en || !supply_ok) |=> (!hs_on && !ls_on));

  assert_hs_waits_feedback_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> $past(ls_discharged));

  assert_ls_waits_feedback_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_on) |-> $past(hs_discharged));

  assert_dead_time_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_on) || $rose(ls_on)) |-> (lowrun_q >= LOW_W'(DEAD_CYC)));

  assert_emulation_release_R8: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && zero_cross && ls_on) |=> !ls_on);

endmodule

bind gsq_gate_sequencer gsq_gate_sequencer_checker #(.DEAD_CYC(DEAD_CYC)) u_checker (
  .clk           (clk),
  .rst           (rst),
  .en            (en),
  .supply_ok     (supply_ok),
  .sync_mode     (sync_mode),
  .zero_cross    (zero_cross),
  .hs_discharged (hs_discharged),
  .ls_discharged (ls_discharged),
  .hs_on         (hs_on),
  .ls_on         (ls_on)
);

// File: tb/gsq_gate_sequencer_bench.sv
module gsq_gate_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 4;
  localparam int HOLD = 34;
  localparam int REC  = 7;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  logic rst, en, supply_ok, sync_mode, pwm_hi, pwm_lo, zero_cross;
  logic hs_discharged, ls_discharged, hs_on, ls_on;
  logic hs_mdl, ls_mdl, hs_stuck, ls_stuck;
  int   n_chk = 0;
  int   n_fail = 0;
  int   n_overlap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gsq_gate_sequencer #(
    .DEAD_CYC(DEAD), .HOLD_CYC(HOLD), .RECOVER_CYC(REC), .DISCH_TIMEOUT(TMO)
  ) u_gsq_gate_sequencer (
    .clk(clk), .rst(rst), .en(en), .supply_ok(supply_ok), .sync_mode(sync_mode),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .hs_discharged(hs_discharged),
    .ls_discharged(ls_discharged), .zero_cross(zero_cross),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  // gate discharge model: one cycle after a gate drops it reads as off
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_mdl <= 1'b1;
      ls_mdl <= 1'b1;
    end else begin
      hs_mdl <= !hs_on;
      ls_mdl <= !ls_on;
    end
  end
  assign hs_discharged = hs_mdl && !hs_stuck;
  assign ls_discharged = ls_mdl && !ls_stuck;

  always @(negedge clk) if (!rst && hs_on && ls_on) n_overlap++;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pwm(input logic h, input logic l);
    pwm_hi = h;
    pwm_lo = l;
  endtask

  // change command and measure the both-off gap
  task automatic switch_and_measure(input logic to_hs, input string req);
    int gap;
    set_pwm(to_hs, !to_hs);
    cyc(1);
    check(req, "old gate held for filter edge", to_hs ? ls_on : hs_on, 1'b1);
    cyc(1);
    check(req, "both off after release", hs_on | ls_on, 1'b0);
    gap = 1;
    for (int i = 0; i < 20; i++) begin
      if (to_hs ? hs_on : ls_on) break;
      cyc(1);
      if (!hs_on && !ls_on) gap++;
    end
    check_int("R7", "dead-time gap", gap, DEAD);
    check("R3", "target gate on", to_hs ? hs_on : ls_on, 1'b1);
    check("R3", "other gate off", to_hs ? ls_on : hs_on, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1; en = 1'b1; supply_ok = 1'b1; sync_mode = 1'b1;
    zero_cross = 1'b0; hs_stuck = 1'b0; ls_stuck = 1'b0;
    set_pwm(1'b0, 1'b0);
    cyc(3);
    check("R12", "outputs in reset", hs_on | ls_on, 1'b0);
    rst = 1'b0;
    cyc(6);
    check("R12", "outputs after reset", hs_on | ls_on, 1'b0);
  endtask

  task automatic t_recovery;
    set_pwm(1'b1, 1'b0);
    cyc(3);
    set_pwm(1'b0, 1'b0);
    cyc(10);
    check("R5", "short pulse ignored", hs_on, 1'b0);
    set_pwm(1'b1, 1'b0);
    cyc(REC);
    check("R5", "still off at recovery edge", hs_on, 1'b0);
    cyc(1);
    check("R5", "drive resumed", hs_on, 1'b1);
    check("R3", "low side off with high cmd", ls_on, 1'b0);
  endtask

  task automatic t_sync_switch;
    switch_and_measure(1'b0, "R3");
    switch_and_measure(1'b1, "R3");
  endtask

  task automatic t_holdoff;
    set_pwm(1'b0, 1'b0);
    cyc(20);
    check("R4", "short mid excursion ignored", hs_on, 1'b1);
    set_pwm(1'b1, 1'b0);
    cyc(5);
    set_pwm(1'b0, 1'b0);
    cyc(HOLD);
    check("R4", "still on at hold-off edge", hs_on, 1'b1);
    cyc(1);
    check("R4", "off after hold-off", hs_on, 1'b0);
    set_pwm(1'b1, 1'b0);
    cyc(REC + 1);
    check("R5", "high side back", hs_on, 1'b1);
    set_pwm(1'b1, 1'b1);
    cyc(HOLD + 1);
    check("R4", "double assert treated as mid", hs_on | ls_on, 1'b0);
    set_pwm(1'b0, 1'b1);
    cyc(REC + 1);
    check("R5", "low side back", ls_on, 1'b1);
  endtask

  task automatic t_enable;
    en = 1'b0;
    cyc(1);
    check("R1", "off after enable drop", ls_on, 1'b0);
    set_pwm(1'b1, 1'b0);
    cyc(10);
    check("R1", "pwm ignored while disabled", hs_on | ls_on, 1'b0);
    en = 1'b1;
    cyc(1);
    check("R1", "high side after re-enable", hs_on, 1'b1);
  endtask

  task automatic t_supply;
    supply_ok = 1'b0;
    cyc(1);
    check("R2", "off after supply loss", hs_on, 1'b0);
    set_pwm(1'b0, 1'b1);
    cyc(10);
    check("R2", "pwm ignored without supply", hs_on | ls_on, 1'b0);
    supply_ok = 1'b1;
    cyc(1);
    check("R2", "low side after supply return", ls_on, 1'b1);
  endtask

  task automatic t_feedback;
    ls_stuck = 1'b1;
    set_pwm(1'b1, 1'b0);
    cyc(20);
    check("R6", "high side waits for discharge", hs_on | ls_on, 1'b0);
    ls_stuck = 1'b0;
    cyc(1);
    check("R6", "high side on after discharge", hs_on, 1'b1);
  endtask

  task automatic t_timeout;
    hs_stuck = 1'b1;
    set_pwm(1'b0, 1'b1);
    cyc(TMO + 20);
    check("R10", "off while feedback missing", hs_on | ls_on, 1'b0);
    hs_stuck = 1'b0;
    cyc(10);
    check("R10", "fault latched after late feedback", ls_on, 1'b0);
    en = 1'b0;
    cyc(2);
    en = 1'b1;
    cyc(2);
    check("R10", "cleared by enable cycle", ls_on, 1'b1);
  endtask

  task automatic t_zero_cross;
    zero_cross = 1'b1;
    cyc(3);
    check("R9", "sync mode ignores zero cross", ls_on, 1'b1);
    zero_cross = 1'b0;
    switch_and_measure(1'b1, "R3");
    sync_mode = 1'b0;
    cyc(2);
    check("R8", "high side unaffected by emulation", hs_on, 1'b1);
    switch_and_measure(1'b0, "R8");
    zero_cross = 1'b1;
    cyc(1);
    check("R8", "low side released on zero cross", ls_on, 1'b0);
    zero_cross = 1'b0;
    cyc(20);
    check("R8", "low side stays off", hs_on | ls_on, 1'b0);
    set_pwm(1'b1, 1'b0);
    cyc(2);
    check("R8", "high side next cycle", hs_on, 1'b1);
    switch_and_measure(1'b0, "R8");
    sync_mode = 1'b1;
  endtask

  initial begin
    t_reset();
    t_recovery();
    t_sync_switch();
    t_holdoff();
    t_enable();
    t_supply();
    t_feedback();
    t_timeout();
    t_zero_cross();
    check_int("R11", "cycles with both gates on", n_overlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule